// File: doc/BRIEF.md
# Serial Register Slave with Chain Forwarding and Indirect Window

This block is the control-port end of a peripheral: a byte-framed serial slave that lets a host read and write a small direct register file. Each access is an address/control byte followed by one data byte. When chain mode is on, a select byte comes first. The block takes its own select from that byte's last bit. It passes the byte on through a forwarding output, delayed by one serial clock, so the next device in the chain finds its own select bit in the least significant position.

A second storage space, which the direct file does not map, is reached through a window of three direct registers: a 16-bit data word and an address. That space is served only when a slow periodic update strobe arrives. A status bit shows the pending transfer. Completion raises a pending flag, which software clears by writing 1, and which can drive an active-low interrupt through an enable.

The serial inputs are taken to be synchronous to the system clock and slower than it by at least four clocks per half period. The block detects the serial clock edges by comparing against a registered copy. The serial data output is shown as a data bit plus an output enable, and the interrupt is shown as a pull-low enable.

Top module: `spi_chain_regslave`

## Requirements
- R1: After reset the output enable, the interrupt pull and the forwarding output are 0, and register 0x00 (config) and register 0x15 (indirect status) read 0.
- R2: Bits go MSB first. Data is sampled on rising SCLK and driven on falling SCLK. In the address/control byte, bit 7 = 1 means read and bit 7 = 0 means write, and bits 6:0 give the register address. Scratch registers sit at 0x20 to 0x27 and unmapped addresses read 0.
- R3: While cs_n is high, SCLK and SDI change no register and sdo_oe stays 0.
- R4: With config bit 7 set, every access starts with a select byte. The block takes part only if bit 0 of that byte is 1. When it does not take part, a write has no effect and sdo_oe stays 0.
- R5: During the select byte, sdi_thru carries SDI delayed by one SCLK, starting from 0. The next device therefore samples the select byte shifted right by one bit, with a 0 in its MSB.
- R6: During the address and data bytes, sdi_thru equals SDI.
- R7: Config bit 6 controls when the output is released. When it is 1, sdo_oe drops at the rising SCLK of the last data bit. When it is 0, sdo_oe stays 1 until cs_n rises.
- R8: Writing the data word (0x12 low byte, 0x13 high byte) and then the address (0x14) stores the word at that indirect address on the next update strobe.
- R9: Writing only the address starts an indirect read. At the next update strobe the data registers take the stored word.
- R10: Bit 0 of 0x15 (busy) is 1 from the address write until the update strobe that serves the transfer.
- R11: Completing a transfer sets bit 0 of 0x10 (pending). Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R12: irq_pull is 1 exactly when the pending bit and bit 0 of 0x11 (enable) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low select |
| sdi | input | 1 | Serial data in |
| upd_tick | input | 1 | Periodic update strobe for the indirect window |
| sdo | output | 1 | Serial data out, valid while sdo_oe is 1 |
| sdo_oe | output | 1 | Output enable for sdo |
| sdi_thru | output | 1 | Forwarded serial data for the next chained device |
| irq_pull | output | 1 | 1 pulls the active-low interrupt line low |

## Verification
The hardest states to reach are the ones a single device shows only partly: the downstream device's view of the select byte, and the window between an indirect address write and its update strobe. The bench samples sdi_thru just before each rising SCLK, exactly as a following device would, and rebuilds the byte that device receives. The bench drives the update strobe by hand, so it can read the busy bit and the data registers inside that window. It also preloads the data registers with values that differ from the stored word, which shows that an indirect read really loads them.

// File: rtl/sds_pkg.sv
// Shared types and direct register map for the serial register slave.
package sds_pkg;
    typedef enum logic [1:0] {
        PH_CSB  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_DONE = 2'd3
    } phase_t;

    localparam logic [6:0] REG_CFG  = 7'h00;
    localparam logic [6:0] REG_PEND = 7'h10;
    localparam logic [6:0] REG_EN   = 7'h11;
    localparam logic [6:0] REG_IDL  = 7'h12;
    localparam logic [6:0] REG_IDH  = 7'h13;
    localparam logic [6:0] REG_IAD  = 7'h14;
    localparam logic [6:0] REG_STAT = 7'h15;
endpackage

// File: rtl/sds_frame.sv
// Serial framing engine. Detects SCLK edges by oversampling with clk, steps
// through the select / address / data bytes, forwards SDI downstream and
// shifts read data out. Assumes sclk, cs_n and sdi are synchronous to clk.
module sds_frame
    import sds_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       sdi,
    input  logic       chain_en,
    input  logic       sdo_early,
    input  logic [7:0] rdata,
    output logic [6:0] acc_addr,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic       sdo,
    output logic       sdo_oe,
    output logic       sdi_thru
);
    logic       sclk_q;
    logic       rise, fall;
    phase_t     phase;
    logic [2:0] bitcnt;
    logic [6:0] shreg;
    logic [7:0] byte_in;
    logic       sel_q, rd_q, thru_q;
    logic [7:0] out_q;

    // Edge detection, qualified by an active select.
    assign rise    = sclk & ~sclk_q & ~cs_n;
    assign fall    = ~sclk & sclk_q & ~cs_n;
    assign byte_in = {shreg, sdi};

    // Frame state, shifting, decode of completed bytes and output shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b1;
            phase    <= PH_ADDR;
            bitcnt   <= '0;
            shreg    <= '0;
            sel_q    <= 1'b1;
            rd_q     <= 1'b0;
            thru_q   <= 1'b0;
            out_q    <= '0;
            sdo_oe   <= 1'b0;
            acc_addr <= '0;
            wr_en    <= 1'b0;
            wr_data  <= '0;
        end else begin
            sclk_q <= sclk;
            wr_en  <= 1'b0;
            if (cs_n) begin
                phase  <= chain_en ? PH_CSB : PH_ADDR;
                bitcnt <= '0;
                sel_q  <= ~chain_en;
                thru_q <= 1'b0;
                sdo_oe <= 1'b0;
            end else begin
                if (rise) begin
                    shreg  <= byte_in[6:0];
                    bitcnt <= bitcnt + 3'd1;
                    if (phase == PH_CSB)
                        thru_q <= sdi;
                    if (bitcnt == 3'd7) begin
                        case (phase)
                            PH_CSB: begin
                                sel_q <= sdi;
                                phase <= PH_ADDR;
                            end
                            PH_ADDR: begin
                                rd_q     <= byte_in[7];
                                acc_addr <= byte_in[6:0];
                                phase    <= PH_DATA;
                            end
                            PH_DATA: begin
                                if (sel_q && !rd_q) begin
                                    wr_en   <= 1'b1;
                                    wr_data <= byte_in;
                                end
                                if (sdo_early)
                                    sdo_oe <= 1'b0;
                                phase <= PH_DONE;
                            end
                            default: phase <= PH_DONE;
                        endcase
                    end
                end
                if (fall && phase == PH_DATA && sel_q && rd_q) begin
                    if (bitcnt == 3'd0) begin
                        out_q  <= rdata;
                        sdo_oe <= 1'b1;
                    end else begin
                        out_q <= {out_q[6:0], 1'b0};
                    end
                end
            end
        end
    end

    // Forwarding path: delayed copy during the select byte, straight through after.
    always_comb begin
        if (cs_n)
            sdi_thru = 1'b0;
        else if (phase == PH_CSB)
            sdi_thru = thru_q;
        else
            sdi_thru = sdi;
    end

    assign sdo = out_q[7];

    a_r3_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sdo_oe);
    a_r4_unselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && !sel_q) |-> !sdo_oe);
    a_r5_thru_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CSB && rise && bitcnt != 3'd7) |=> (sdi_thru == $past(sdi)));
    a_r7_early_release: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_early && phase == PH_DATA && rise && bitcnt == 3'd7) |=> !sdo_oe);
endmodule

// File: rtl/sds_indirect.sv
// Indirect access window. Holds the data word and address, stages a write
// when data was written before the address, and serves the request on the
// next update strobe. Addresses index the store modulo its depth.
module sds_indirect #(
    parameter int IND_AW = 4,
    parameter int DW     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic          wr_addr,
    input  logic [7:0]    wdata,
    input  logic          upd_tick,
    output logic [DW-1:0] data_q,
    output logic [7:0]    addr_q,
    output logic          busy_q,
    output logic          done
);
    localparam int DEPTH = 1 << IND_AW;

    logic [DW-1:0] mem [DEPTH];
    logic          staged_q, op_wr_q;

    // Window registers, request staging and servicing on the update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
            data_q   <= '0;
            addr_q   <= '0;
            busy_q   <= 1'b0;
            staged_q <= 1'b0;
            op_wr_q  <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (wr_lo) begin
                data_q[7:0] <= wdata;
                staged_q    <= 1'b1;
            end
            if (wr_hi) begin
                data_q[DW-1:8] <= wdata[DW-9:0];
                staged_q       <= 1'b1;
            end
            if (wr_addr) begin
                addr_q   <= wdata;
                busy_q   <= 1'b1;
                op_wr_q  <= staged_q;
                staged_q <= 1'b0;
            end else if (upd_tick && busy_q) begin
                busy_q <= 1'b0;
                done   <= 1'b1;
                if (op_wr_q)
                    mem[addr_q[IND_AW-1:0]] <= data_q;
                else
                    data_q <= mem[addr_q[IND_AW-1:0]];
            end
        end
    end

    a_r10_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !upd_tick) |=> busy_q);
endmodule

// File: rtl/sds_regs.sv
// Direct register file: configuration, interrupt pending / enable, scratch
// registers and the read multiplexer. Decodes writes into window strobes.
module sds_regs
    import sds_pkg::*;
#(
    parameter int NSCR     = 8,
    parameter int SCR_BASE = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [6:0]  addr,
    input  logic        wr_en,
    input  logic [7:0]  wdata,
    input  logic [15:0] ind_data,
    input  logic [7:0]  ind_addr,
    input  logic        ind_busy,
    input  logic        ind_done,
    output logic [7:0]  rdata,
    output logic        chain_en,
    output logic        sdo_early,
    output logic        wr_lo,
    output logic        wr_hi,
    output logic        wr_addr,
    output logic        irq_pull
);
    localparam int SCR_AW = (NSCR > 1) ? $clog2(NSCR) : 1;

    logic [7:0]        scr_q [NSCR];
    logic              pend_q, en_q;
    logic [31:0]       a32;
    logic              scr_hit;
    logic [SCR_AW-1:0] scr_idx;

    assign a32     = 32'(addr);
    assign scr_hit = (a32 >= 32'(SCR_BASE)) && (a32 < 32'(SCR_BASE + NSCR));
    assign scr_idx = SCR_AW'(a32 - 32'(SCR_BASE));

    assign wr_lo   = wr_en && addr == REG_IDL;
    assign wr_hi   = wr_en && addr == REG_IDH;
    assign wr_addr = wr_en && addr == REG_IAD;

    // Configuration, enable, scratch and write-one-to-clear pending bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_en  <= 1'b0;
            sdo_early <= 1'b0;
            en_q      <= 1'b0;
            pend_q    <= 1'b0;
            for (int i = 0; i < NSCR; i++)
                scr_q[i] <= '0;
        end else begin
            if (wr_en && addr == REG_CFG) begin
                chain_en  <= wdata[7];
                sdo_early <= wdata[6];
            end
            if (wr_en && addr == REG_EN)
                en_q <= wdata[0];
            if (wr_en && addr == REG_PEND && wdata[0])
                pend_q <= 1'b0;
            if (ind_done)
                pend_q <= 1'b1;
            if (wr_en && scr_hit)
                scr_q[scr_idx] <= wdata;
        end
    end

    // Read multiplexer over the direct map.
    always_comb begin
        rdata = '0;
        if (scr_hit)
            rdata = scr_q[scr_idx];
        else begin
            case (addr)
                REG_CFG:  rdata = {chain_en, sdo_early, 6'b0};
                REG_PEND: rdata = {7'b0, pend_q};
                REG_EN:   rdata = {7'b0, en_q};
                REG_IDL:  rdata = ind_data[7:0];
                REG_IDH:  rdata = ind_data[15:8];
                REG_IAD:  rdata = ind_addr;
                REG_STAT: rdata = {7'b0, ind_busy};
                default:  rdata = '0;
            endcase
        end
    end

    assign irq_pull = pend_q & en_q;

    a_r11_pend_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ind_busy) |=> pend_q);
    a_r12_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pull) |-> en_q);
endmodule

// File: rtl/spi_chain_regslave.sv
// Top level: serial register slave with chain forwarding and an indirect
// access window served on a periodic update strobe.
module spi_chain_regslave #(
    parameter int IND_AW   = 4,
    parameter int NSCR     = 8,
    parameter int SCR_BASE = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    input  logic upd_tick,
    output logic sdo,
    output logic sdo_oe,
    output logic sdi_thru,
    output logic irq_pull
);
    logic [6:0]  acc_addr;
    logic        wr_en;
    logic [7:0]  wr_data;
    logic [7:0]  rdata;
    logic        chain_en, sdo_early;
    logic        wr_lo, wr_hi, wr_addr;
    logic [15:0] ind_data;
    logic [7:0]  ind_addr;
    logic        ind_busy, ind_done;

    sds_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .sdi      (sdi),
        .chain_en (chain_en),
        .sdo_early(sdo_early),
        .rdata    (rdata),
        .acc_addr (acc_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe),
        .sdi_thru (sdi_thru)
    );

    sds_regs #(.NSCR(NSCR), .SCR_BASE(SCR_BASE)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (acc_addr),
        .wr_en    (wr_en),
        .wdata    (wr_data),
        .ind_data (ind_data),
        .ind_addr (ind_addr),
        .ind_busy (ind_busy),
        .ind_done (ind_done),
        .rdata    (rdata),
        .chain_en (chain_en),
        .sdo_early(sdo_early),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .wr_addr  (wr_addr),
        .irq_pull (irq_pull)
    );

    sds_indirect #(.IND_AW(IND_AW), .DW(16)) u_ind (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_addr (wr_addr),
        .wdata   (wr_data),
        .upd_tick(upd_tick),
        .data_q  (ind_data),
        .addr_q  (ind_addr),
        .busy_q  (ind_busy),
        .done    (ind_done)
    );
endmodule

// File: tb/sim_spi_chain_regslave.sv
module sim_spi_chain_regslave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, cs_n = 1'b1, sdi = 1'b0, upd_tick = 1'b0;
    logic sdo, sdo_oe, sdi_thru, irq_pull;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] act_byte;
    event       rd_ev;

    bit         chain_on = 0;
    logic [7:0] csb_val = 8'h01;
    logic [7:0] down_byte;
    logic       oe_tail, oe_seen;
    int         thru_bad;

    always #5 clk = ~clk;

    spi_chain_regslave u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .upd_tick(upd_tick), .sdo(sdo), .sdo_oe(sdo_oe),
        .sdi_thru(sdi_thru), .irq_pull(irq_pull)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One serial byte; returns the bits seen on sdo and on sdi_thru before each rise.
    task automatic xbyte(input logic [7:0] b, input bit is_csb,
                         output logic [7:0] so, output logic [7:0] th);
        for (int i = 7; i >= 0; i--) begin
            sclk = 1'b0;
            sdi  = b[i];
            repeat (4) @(negedge clk);
            so[i] = sdo;
            th[i] = sdi_thru;
            if (sdo_oe) oe_seen = 1'b1;
            if (!is_csb && sdi_thru !== sdi) thru_bad++;
            sclk = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic xfer(input logic [7:0] ab, input logic [7:0] db, output logic [7:0] rd);
        logic [7:0] so, th;
        oe_seen = 1'b0;
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        if (chain_on) begin
            xbyte(csb_val, 1'b1, so, th);
            down_byte = th;
        end
        xbyte(ab, 1'b0, so, th);
        xbyte(db, 1'b0, rd, th);
        oe_tail = sdo_oe;
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic spi_wr(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] rd;
        xfer({1'b0, a}, d, rd);
    endtask

    // Driver side of the scoreboard: expected byte pushed, captured byte published.
    task automatic spi_rd(input logic [6:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] rd;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        xfer({1'b1, a}, 8'h00, rd);
        act_byte = rd;
        ->rd_ev;
        @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) upd_tick = 1'b1;
        @(negedge clk) upd_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Monitor side of the scoreboard.
    initial begin
        forever begin
            @(rd_ev);
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL scoreboard: actual %0h expected none", act_byte);
            end else begin
                chk(tag_q.pop_front(), 32'(act_byte), 32'(exp_q.pop_front()));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 sdo_oe", 32'(sdo_oe), 0);
        chk("R1 irq_pull", 32'(irq_pull), 0);
        chk("R1 sdi_thru", 32'(sdi_thru), 0);
        spi_rd(7'h00, 8'h00, "R1 cfg");
        spi_rd(7'h15, 8'h00, "R1 status");

        // R2 framing, scratch, unmapped
        spi_wr(7'h20, 8'hA5);
        spi_wr(7'h27, 8'h3C);
        spi_rd(7'h20, 8'hA5, "R2 scratch0");
        spi_rd(7'h27, 8'h3C, "R2 scratch7");
        spi_rd(7'h7F, 8'h00, "R2 unmapped");

        // R3 activity with select high is ignored
        for (int i = 0; i < 16; i++) begin
            sclk = 1'b0; sdi = i[0] ^ i[2];
            repeat (3) @(negedge clk);
            if (sdo_oe) oe_seen = 1'b1;
            sclk = 1'b1;
            repeat (3) @(negedge clk);
        end
        chk("R3 sdo_oe idle", 32'(sdo_oe), 0);
        spi_rd(7'h20, 8'hA5, "R3 scratch kept");

        // R7 release timing, late mode then early mode
        spi_rd(7'h27, 8'h3C, "R7 late data");
        chk("R7 late oe held", 32'(oe_tail), 1);
        chk("R7 oe after cs", 32'(sdo_oe), 0);
        spi_wr(7'h00, 8'h40);
        spi_rd(7'h20, 8'hA5, "R7 early data");
        chk("R7 early oe released", 32'(oe_tail), 0);
        spi_wr(7'h00, 8'h00);

        // R4 R5 R6 chain mode
        spi_wr(7'h00, 8'h80);
        chain_on = 1; csb_val = 8'hB5;
        thru_bad = 0;
        spi_rd(7'h20, 8'hA5, "R4 selected read");
        chk("R5 downstream byte", 32'(down_byte), 32'h5A);
        chk("R6 thru equals sdi", 32'(thru_bad), 0);
        csb_val = 8'h02;
        spi_wr(7'h20, 8'hFF);
        chk("R5 downstream sel", 32'(down_byte), 32'h01);
        xfer({1'b1, 7'h20}, 8'h00, act_byte);
        chk("R4 unselected no drive", 32'(oe_seen), 0);
        csb_val = 8'h03;
        spi_rd(7'h20, 8'hA5, "R4 write ignored");
        spi_wr(7'h00, 8'h00);
        chain_on = 0;

        // R8 R10 R11 R12 indirect write and completion
        spi_wr(7'h12, 8'h34);
        spi_wr(7'h13, 8'h12);
        spi_wr(7'h14, 8'h05);
        spi_rd(7'h15, 8'h01, "R10 busy pending");
        tick();
        spi_rd(7'h15, 8'h00, "R10 busy cleared");
        spi_rd(7'h10, 8'h01, "R11 pending set");
        chk("R12 masked", 32'(irq_pull), 0);
        spi_wr(7'h11, 8'h01);
        chk("R12 enabled", 32'(irq_pull), 1);
        spi_wr(7'h10, 8'h00);
        spi_rd(7'h10, 8'h01, "R11 write zero kept");
        spi_wr(7'h10, 8'h01);
        spi_rd(7'h10, 8'h00, "R11 w1c");
        chk("R12 cleared", 32'(irq_pull), 0);

        // R9 indirect read overwrites different data registers
        spi_wr(7'h12, 8'h99);
        spi_wr(7'h13, 8'h88);
        spi_wr(7'h14, 8'h06);
        tick();
        spi_wr(7'h14, 8'h05);
        spi_rd(7'h12, 8'h99, "R9 data before tick");
        tick();
        spi_rd(7'h12, 8'h34, "R9 low loaded");
        spi_rd(7'h13, 8'h12, "R9 high loaded");
        chk("R12 raised again", 32'(irq_pull), 1);
        spi_wr(7'h14, 8'h06);
        tick();
        spi_rd(7'h12, 8'h99, "R8 stored low");
        spi_rd(7'h13, 8'h88, "R8 stored high");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule